// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is a battery-domain time keeper that runs on the 32.768 kHz clock. Every clock edge adds one to a fractional sub-second word; when that word rolls over, the whole-seconds word advances. With the default widths (32-bit seconds, 15-bit fraction) the two words form a 47-bit count. The seconds value is compared against an alarm word. A match raises a sticky alarm flag, and that flag drives an interrupt when the interrupt enable is set.

Software reaches the block through a simple write port with five addresses: seconds (0), fraction (1), alarm (2), control (3) and status (4). The counter and flag values are always visible on output ports. A tamper monitor next to the block supplies four freeze inputs:

- a failure indication, which holds the time of a violation;
- a non-valid indication, which stops counting and disarms the counter;
- a hard lock and a soft lock, each of which refuses writes to the timekeeping registers.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the seconds and fraction read 0, both flags and the interrupt are low, the alarm word is all-ones and the counter does not run.
- R2: While running, the fraction increases by one per clock; when it steps past all-ones it returns to 0 and the seconds increase by one in the same cycle.
- R3: The counter runs only when control bit 0 (count enable) is set and a seconds write (address 0) has armed it since reset; enabling without that write leaves the count unchanged.
- R4: When the seconds step past all-ones they wrap to 0 and the overflow flag (status bit 1) sets; counting stays stopped until a write of 1 to status bit 1 clears the flag.
- R5: While the failure input is high, the seconds and fraction hold their values and writes to addresses 0 and 1 are refused.
- R6: While the non-valid input is high, counting stops and the arm is lost; after it falls, counting resumes only after a new seconds write.
- R7: While either lock input is high, writes to the seconds, the fraction and control bit 0 are refused.
- R8: The alarm flag (status bit 0) sets one clock after the seconds first equal the alarm word; the interrupt output equals the flag ANDed with control bit 1.
- R9: Writing 1 to status bit 0 clears the alarm flag, unless a new alarm match arises in the same cycle, which wins.
- R10: An all-ones alarm word never sets the alarm flag, even when the seconds are all-ones.
- R11: A write to address 1 loads the fraction directly from the low data bits, and counting continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock; one fraction step per edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 seconds, 1 fraction, 2 alarm, 3 control, 4 status |
| wr_data | input | SEC_W | Write data |
| fail_in | input | 1 | Failure state from the tamper monitor; freezes the time |
| nonvalid_in | input | 1 | Non-valid state from the tamper monitor; stops and disarms |
| lock_hard | input | 1 | Hard lock on the timer registers |
| lock_soft | input | 1 | Soft lock on the timer registers |
| sec_o | output | SEC_W | Whole seconds |
| frac_o | output | FRAC_W | Sub-second fraction |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| ovf_flag_o | output | 1 | Sticky seconds overflow flag |
| alarm_irq_o | output | 1 | Alarm interrupt request |

## Verification
The bench builds the block with SEC_W = 8 and FRAC_W = 3, so one second lasts eight clocks and the seconds word is all-ones at 255. These widths make the fraction carry, the all-ones seconds wrap with its overflow flag, and an all-ones alarm word against all-ones seconds reachable in a few cycles each. The same widths let every expected value be computed by hand. With those values the bench places the collision between a new alarm match and a flag clear on an exact clock edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    RA_SEC    = 3'd0,
    RA_FRAC   = 3'd1,
    RA_ALARM  = 3'd2,
    RA_CTRL   = 3'd3,
    RA_STATUS = 3'd4
  } rtc_reg_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IRQ_BIT = 1;
  localparam int ST_ALARM_BIT = 0;
  localparam int ST_OVF_BIT   = 1;

endpackage

// File: rtl/rtc_time_count.sv
module rtc_time_count #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sec_ld,
  input  logic [SEC_W-1:0]  sec_val,
  input  logic              frac_ld,
  input  logic [FRAC_W-1:0] frac_val,
  output logic [SEC_W-1:0]  sec_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic              sec_wrap
);

  localparam logic [FRAC_W-1:0] FRAC_TOP = '1;
  localparam logic [SEC_W-1:0]  SEC_TOP  = '1;

  logic frac_carry;

  // a fraction load suppresses the carry from the old fraction
  assign frac_carry = run & ~frac_ld & (frac_q == FRAC_TOP);
  assign sec_wrap   = frac_carry & ~sec_ld & (sec_q == SEC_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      sec_q  <= '0;
    end else begin
      if (frac_ld)  frac_q <= frac_val;
      else if (run) frac_q <= frac_q + FRAC_W'(1);
      if (sec_ld)          sec_q <= sec_val;
      else if (frac_carry) sec_q <= sec_q + SEC_W'(1);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !sec_ld && !frac_ld) |=> ($stable(sec_q) && $stable(frac_q))); // R3

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] sec_q,
  input  logic [SEC_W-1:0] alarm_q,
  output logic             hit_o
);

  localparam logic [SEC_W-1:0] UNSET = '1;

  logic match_now;
  logic match_d;

  assign match_now = (sec_q == alarm_q) && (alarm_q != UNSET);
  assign hit_o     = match_now & ~match_d;

  always_ff @(posedge clk) begin
    if (rst) match_d <= 1'b0;
    else     match_d <= match_now;
  end

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [SEC_W-1:0]  wr_data,
  input  logic              fail_in,
  input  logic              nonvalid_in,
  input  logic              lock_hard,
  input  logic              lock_soft,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              alarm_flag_o,
  output logic              ovf_flag_o,
  output logic              alarm_irq_o
);

  localparam logic [SEC_W-1:0]  ALARM_UNSET = '1;
  localparam logic [SEC_W-1:0]  SEC_TOP     = '1;
  localparam logic [FRAC_W-1:0] FRAC_TOP    = '1;

  logic              locked;
  logic              sec_wr, frac_wr, alarm_wr, ctrl_wr, st_wr;
  logic              sec_ok, frac_ok;
  logic              en_q, ien_q, armed_q;
  logic              ien_nxt, alarm_nxt, ovf_nxt;
  logic [SEC_W-1:0]  alarm_q;
  logic              run;
  logic              sec_wrap;
  logic              hit;
  logic              unused_data;

  assign unused_data = ^wr_data;

  // write decode
  assign locked   = lock_hard | lock_soft;
  assign sec_wr   = wr_en && (wr_addr == RA_SEC);
  assign frac_wr  = wr_en && (wr_addr == RA_FRAC);
  assign alarm_wr = wr_en && (wr_addr == RA_ALARM);
  assign ctrl_wr  = wr_en && (wr_addr == RA_CTRL);
  assign st_wr    = wr_en && (wr_addr == RA_STATUS);
  assign sec_ok   = sec_wr  & ~locked & ~fail_in;
  assign frac_ok  = frac_wr & ~locked & ~fail_in;

  assign run = en_q & armed_q & ~ovf_flag_o & ~nonvalid_in & ~fail_in;

  rtc_time_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sec_ld   (sec_ok),
    .sec_val  (wr_data),
    .frac_ld  (frac_ok),
    .frac_val (wr_data[FRAC_W-1:0]),
    .sec_q    (sec_o),
    .frac_q   (frac_o),
    .sec_wrap (sec_wrap)
  );

  rtc_alarm_match #(.SEC_W(SEC_W)) u_match (
    .clk     (clk),
    .rst     (rst),
    .sec_q   (sec_o),
    .alarm_q (alarm_q),
    .hit_o   (hit)
  );

  // a new event wins over a clear in the same cycle
  assign alarm_nxt = hit | (alarm_flag_o & ~(st_wr & wr_data[ST_ALARM_BIT]));
  assign ovf_nxt   = sec_wrap | (ovf_flag_o & ~(st_wr & wr_data[ST_OVF_BIT]));
  assign ien_nxt   = ctrl_wr ? wr_data[CTRL_IRQ_BIT] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q      <= ALARM_UNSET;
      en_q         <= 1'b0;
      ien_q        <= 1'b0;
      armed_q      <= 1'b0;
      alarm_flag_o <= 1'b0;
      ovf_flag_o   <= 1'b0;
      alarm_irq_o  <= 1'b0;
    end else begin
      if (alarm_wr) alarm_q <= wr_data;
      if (ctrl_wr && !locked) en_q <= wr_data[CTRL_RUN_BIT];
      ien_q <= ien_nxt;
      if (nonvalid_in) armed_q <= 1'b0;
      else if (sec_ok) armed_q <= 1'b1;
      alarm_flag_o <= alarm_nxt;
      ovf_flag_o   <= ovf_nxt;
      alarm_irq_o  <= alarm_nxt & ien_nxt;
    end
  end

  AST_FAIL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    fail_in |=> ($stable(sec_o) && $stable(frac_o))); // R5

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag_o && !wr_en) |=> $stable(frac_o)); // R4

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
    (run && sec_o == SEC_TOP && frac_o == FRAC_TOP && !wr_en) |=> ovf_flag_o); // R4

  AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (locked && ctrl_wr) |=> $stable(en_q)); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    alarm_irq_o |-> alarm_flag_o); // R8

  AST_UNSET_QUIET: assert property (@(posedge clk) disable iff (rst)
    (alarm_q == ALARM_UNSET && !alarm_flag_o) |=> !alarm_flag_o); // R10

endmodule

// File: tb/rtc_sec_alarm_tb_top.sv
module rtc_sec_alarm_tb_top;

  localparam int SEC_W  = 8;
  localparam int FRAC_W = 3;

  localparam int SEL_SEC  = 0;
  localparam int SEL_FRAC = 1;
  localparam int SEL_AFLG = 2;
  localparam int SEL_OFLG = 3;
  localparam int SEL_IRQ  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [SEC_W-1:0]  wr_data = '0;
  logic              fail_in = 1'b0;
  logic              nonvalid_in = 1'b0;
  logic              lock_hard = 1'b0;
  logic              lock_soft = 1'b0;
  logic [SEC_W-1:0]  sec_o;
  logic [FRAC_W-1:0] frac_o;
  logic              alarm_flag_o, ovf_flag_o, alarm_irq_o;

  always #5 clk = ~clk;

  rtc_sec_alarm #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fail_in(fail_in), .nonvalid_in(nonvalid_in),
    .lock_hard(lock_hard), .lock_soft(lock_soft),
    .sec_o(sec_o), .frac_o(frac_o), .alarm_flag_o(alarm_flag_o),
    .ovf_flag_o(ovf_flag_o), .alarm_irq_o(alarm_irq_o)
  );

  typedef struct {
    string tag;
    int    sel;
    int    val;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  function automatic int observe(int sel);
    case (sel)
      SEL_SEC:  return int'(sec_o);
      SEL_FRAC: return int'(frac_o);
      SEL_AFLG: return int'(alarm_flag_o);
      SEL_OFLG: return int'(ovf_flag_o);
      default:  return int'(alarm_irq_o);
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t it;
        int   got;
        it  = exp_q.pop_front();
        got = observe(it.sel);
        n_chk++;
        if (got != it.val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, got, it.val);
        end
      end
    end
  end

  task automatic expect_out(string tag, int sel, int val);
    exp_t it;
    it.tag = tag; it.sel = sel; it.val = val;
    exp_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, int d);
    wr_en = 1'b1; wr_addr = a; wr_data = SEC_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_out("R1 seconds", SEL_SEC, 0);
    expect_out("R1 fraction", SEL_FRAC, 0);
    expect_out("R1 alarm flag", SEL_AFLG, 0);
    expect_out("R1 overflow flag", SEL_OFLG, 0);
    expect_out("R1 irq", SEL_IRQ, 0);

    // enabled but never armed
    wr(3'd3, 1);
    step(5);
    expect_out("R3 unarmed frac", SEL_FRAC, 0);
    expect_out("R1 no count", SEL_SEC, 0);

    // arm with seconds write
    wr(3'd0, 10);
    expect_out("R3 armed sec", SEL_SEC, 10);
    expect_out("R3 armed frac", SEL_FRAC, 0);
    step(3);
    expect_out("R2 frac steps", SEL_FRAC, 3);
    step(5);
    expect_out("R2 carry frac", SEL_FRAC, 0);
    expect_out("R2 carry sec", SEL_SEC, 11);

    // disable, load fraction
    wr(3'd3, 0);
    step(3);
    expect_out("R3 disabled hold", SEL_FRAC, 1);
    wr(3'd1, 6);
    expect_out("R11 frac load", SEL_FRAC, 6);
    wr(3'd3, 1);
    step(1);
    expect_out("R11 count from load", SEL_FRAC, 7);
    step(1);
    expect_out("R11 carry after load", SEL_SEC, 12);
    expect_out("R11 frac wrap", SEL_FRAC, 0);

    // locks
    wr(3'd3, 0);
    lock_soft = 1'b1;
    wr(3'd0, 100);
    wr(3'd1, 5);
    wr(3'd3, 1);
    step(3);
    expect_out("R7 soft lock sec", SEL_SEC, 12);
    expect_out("R7 soft lock frac/en", SEL_FRAC, 1);
    lock_soft = 1'b0;
    lock_hard = 1'b1;
    wr(3'd0, 100);
    step(1);
    expect_out("R7 hard lock sec", SEL_SEC, 12);
    lock_hard = 1'b0;

    // failure freeze
    wr(3'd3, 1);
    fail_in = 1'b1;
    wr(3'd0, 50);
    step(3);
    expect_out("R5 fail sec", SEL_SEC, 12);
    expect_out("R5 fail frac", SEL_FRAC, 1);
    fail_in = 1'b0;
    step(2);
    expect_out("R5 resume", SEL_FRAC, 3);

    // non-valid disarms
    nonvalid_in = 1'b1;
    step(3);
    expect_out("R6 nonvalid stop", SEL_FRAC, 3);
    nonvalid_in = 1'b0;
    step(3);
    expect_out("R6 stays disarmed", SEL_FRAC, 3);
    wr(3'd0, 20);
    step(1);
    expect_out("R6 rearmed", SEL_FRAC, 4);
    expect_out("R6 rearm sec", SEL_SEC, 20);

    // alarm
    wr(3'd3, 0);
    wr(3'd2, 21);
    wr(3'd1, 7);
    wr(3'd3, 3);
    step(1);
    expect_out("R8 sec at alarm", SEL_SEC, 21);
    expect_out("R8 flag one cycle later", SEL_AFLG, 0);
    step(1);
    expect_out("R8 flag set", SEL_AFLG, 1);
    expect_out("R8 irq set", SEL_IRQ, 1);
    wr(3'd4, 1);
    expect_out("R9 clear flag", SEL_AFLG, 0);
    expect_out("R9 clear irq", SEL_IRQ, 0);

    // new event beats clear
    wr(3'd3, 2);
    wr(3'd2, 30);
    step(1);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = SEC_W'(21);
    @(negedge clk);
    wr_addr = 3'd4; wr_data = SEC_W'(1);
    @(negedge clk);
    wr_en = 1'b0;
    expect_out("R9 new event wins", SEL_AFLG, 1);
    expect_out("R9 irq follows", SEL_IRQ, 1);
    wr(3'd3, 0);
    expect_out("R8 irq gated off", SEL_IRQ, 0);
    expect_out("R8 flag kept", SEL_AFLG, 1);
    wr(3'd4, 1);
    expect_out("R9 clear no event", SEL_AFLG, 0);

    // unset alarm
    wr(3'd2, 255);
    wr(3'd0, 255);
    step(2);
    expect_out("R10 unset quiet", SEL_AFLG, 0);

    // overflow
    wr(3'd1, 6);
    wr(3'd3, 1);
    step(1);
    expect_out("R4 before wrap", SEL_FRAC, 7);
    step(1);
    expect_out("R4 wrap sec", SEL_SEC, 0);
    expect_out("R4 overflow set", SEL_OFLG, 1);
    step(3);
    expect_out("R4 stopped", SEL_FRAC, 0);
    wr(3'd4, 2);
    expect_out("R4 overflow clear", SEL_OFLG, 0);
    step(2);
    expect_out("R4 counting again", SEL_FRAC, 2);
    expect_out("R10 still quiet", SEL_AFLG, 0);

    wait (exp_q.size() == 0);
    step(1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule